// File: doc/BRIEF.md
# Multichannel Sinc Decimator for Isolated Modulator Bitstreams

This block turns the one-bit data streams of several isolated sigma-delta modulators into signed multi-bit current samples. Every modulator runs from one shared modulator clock. The block brings that clock and the data lines into the system clock domain. It samples each data bit on a synchronised rising edge of the modulator clock and passes it through a cascaded-integrator-comb filter. The filter order (one, two or three) and the oversampling ratio (a power of two from 16 to 256) can be changed while the block runs.

All channels share one window counter. Every sample therefore closes on the same modulator edge, and a single strobe marks a new set of phase samples that all refer to one instant. Two fault indications travel with the samples. The first is a per-channel saturation flag for a bitstream that holds one level for longer than a programmed run length. The second is a stall flag for a modulator clock that has stopped toggling. The clock is shared, so a single stall flag covers all channels. Downstream logic scales the samples to current and checks them for plausibility.

Top module: `sdm_decim`

## Requirements
- R1: A data bit of 1 counts as +1 and a bit of 0 counts as −1. With order N and ratio R, the sample of window k (windows numbered from 1 after the last configuration change, window k ending on stream sample kR−1) equals the sum over j of h[j]·x[kR−1−j]. Here h is the N-fold convolution of a length-R run of ones, and samples before the configuration change count as zero.
- R2: The 3-bit ratio select s gives R = 16·2^s for s from 0 to 4. Any code above 4 gives R = 256.
- R3: The 2-bit order code selects sinc1, sinc2 or sinc3 for the values 1, 2 and 3. Code 0 behaves as order 1.
- R4: A constant stream of ones gives exactly +R^N and a constant stream of zeros gives exactly −R^N, with no wraparound even at order 3 and R = 256. An alternating stream through sinc1 gives 0.
- R5: After reset or any change of order or ratio, the filter state and window counter restart and the first N windows produce no strobe. The first strobe therefore follows sample (N+1)·R−1.
- R6: The valid strobe is high for exactly one system clock, and all channel samples update in that same cycle.
- R7: Samples and saturation flags keep their values between strobes.
- R8: At each strobe, a channel's saturation flag is 1 exactly when, among the samples since the previous strobe (or since the configuration change), its count of consecutive identical bits reached the run limit. Run counting restarts on a configuration change.
- R9: A run limit of 0 disables saturation detection.
- R10: The stall flag rises once STALL_CYCLES system clocks pass with no modulator clock rising edge. It falls on the next strobe.
- R11: Out of reset, all samples, the valid strobe and all flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, several times faster than the modulator clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mclk_i | input | 1 | Shared modulator clock |
| mdat_i | input | NCH | One data bit per modulator channel |
| osr_sel_i | input | OSR_SEL_W | Oversampling ratio select |
| order_i | input | 2 | Filter order code |
| sat_limit_i | input | SAT_W | Run length that counts as saturation; 0 disables |
| sample_o | output | NCH·W | Signed samples, channel 0 in the low bits |
| valid_o | output | 1 | One-cycle strobe for a new set of samples |
| sat_o | output | NCH | Per-channel saturation flags |
| stall_o | output | 1 | Modulator clock stall flag |

## Verification
Uniform random streams check the full impulse-response weighting, including the partly filled windows at start-up. Biased streams keep the samples well away from zero and so expose sign errors. Constant ones and zeros drive the filter to exact full scale at every order and ratio, so a register that is too narrow shows up as a wrapped result. They also produce long runs for the saturation flag. Alternating streams null out under sinc1 and give runs of length one. A limit of 1 forces the flag on, and a limit of 0 forces it off. A pause in the modulator clock, shorter and then longer than the watchdog window, separates a correct stall flag from one raised too early or never cleared.

// File: rtl/sdm_pkg.sv
package sdm_pkg;

    // Deepest supported cascade of integrators and combs.
    localparam int ORDER_MAX = 3;

    // Order code 0 falls back to a single stage.
    function automatic logic [1:0] order_decode(input logic [1:0] code);
        return (code == 2'd0) ? 2'd1 : code;
    endfunction

endpackage

// File: rtl/sdm_front.sv
module sdm_front #(
    parameter int NCH          = 3,
    parameter int STALL_CYCLES = 64
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           mclk_i,
    input  logic [NCH-1:0] mdat_i,
    input  logic           emit_i,
    output logic           tick_o,
    output logic [NCH-1:0] bit_o,
    output logic           stall_o
);
    localparam int              WD_W   = $clog2(STALL_CYCLES + 1);
    localparam logic [WD_W-1:0] WD_LIM = WD_W'(STALL_CYCLES);

    typedef struct packed {
        logic [2:0]      mck;   // [0] first stage, [2] edge reference
        logic [NCH-1:0]  d1;
        logic [NCH-1:0]  d2;
        logic [WD_W-1:0] wd;
        logic            stall;
    } front_t;

    front_t s_d, s_q;

    always_comb begin
        s_d     = s_q;
        s_d.mck = {s_q.mck[1:0], mclk_i};
        s_d.d1  = mdat_i;
        s_d.d2  = s_q.d1;
        tick_o  = s_q.mck[1] & ~s_q.mck[2];
        if (tick_o) begin
            s_d.wd = '0;
        end else if (s_q.wd != WD_LIM) begin
            s_d.wd = s_q.wd + 1'b1;
        end
        if (emit_i) begin
            s_d.stall = 1'b0;
        end else if (s_d.wd == WD_LIM) begin
            s_d.stall = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign bit_o   = s_q.d2;
    assign stall_o = s_q.stall;

    // R10
    stall_after_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stall_o) |-> $past(!tick_o));

endmodule

// File: rtl/sdm_frame.sv
module sdm_frame
    import sdm_pkg::*;
#(
    parameter int LOG2_OSR_MIN = 4,
    parameter int LOG2_OSR_MAX = 8,
    parameter int OSR_SEL_W    = 3,
    parameter int LR_W         = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tick_i,
    input  logic [OSR_SEL_W-1:0] osr_sel_i,
    input  logic [1:0]           order_i,
    output logic                 clr_o,
    output logic                 win_end_o,
    output logic                 emit_o,
    output logic                 valid_o,
    output logic [1:0]           order_o,
    output logic [LR_W-1:0]      log2r_o
);
    localparam int FC_W    = LOG2_OSR_MAX;
    localparam int SEL_CAP = LOG2_OSR_MAX - LOG2_OSR_MIN;

    typedef struct packed {
        logic            armed;
        logic [1:0]      ord;
        logic [LR_W-1:0] lr;
        logic [FC_W-1:0] fcnt;
        logic [1:0]      warm;
        logic            valid;
    } frame_t;

    frame_t s_d, s_q;
    logic [1:0]      ord_n;
    logic [LR_W-1:0] lr_n;
    logic [FC_W-1:0] osr_m1;
    logic            last;

    always_comb begin
        ord_n = order_decode(order_i);
        if (int'(osr_sel_i) > SEL_CAP) lr_n = LR_W'(LOG2_OSR_MAX);
        else                           lr_n = LR_W'(LOG2_OSR_MIN + int'(osr_sel_i));
        osr_m1    = FC_W'((32'd1 << s_q.lr) - 32'd1);
        last      = (s_q.fcnt == osr_m1);
        clr_o     = !s_q.armed || (ord_n != s_q.ord) || (lr_n != s_q.lr);
        win_end_o = tick_i && !clr_o && last;
        emit_o    = win_end_o && (s_q.warm == 2'd0);

        s_d       = s_q;
        s_d.valid = emit_o;
        if (clr_o) begin
            s_d.armed = 1'b1;
            s_d.ord   = ord_n;
            s_d.lr    = lr_n;
            s_d.fcnt  = '0;
            s_d.warm  = ord_n;
        end else if (tick_i) begin
            s_d.fcnt = last ? '0 : s_q.fcnt + 1'b1;
            if (win_end_o && s_q.warm != 2'd0) s_d.warm = s_q.warm - 2'd1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign valid_o = s_q.valid;
    assign order_o = s_q.ord;
    assign log2r_o = s_q.lr;

    // R6
    valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o);

    // R5
    no_early_emit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_o |=> !emit_o);

endmodule

// File: rtl/sdm_chan.sv
module sdm_chan
    import sdm_pkg::*;
#(
    parameter int W     = 26,
    parameter int SAT_W = 12,
    parameter int LR_W  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             tick_i,
    input  logic             bit_i,
    input  logic             win_end_i,
    input  logic             emit_i,
    input  logic [1:0]       order_i,
    input  logic [LR_W-1:0]  log2r_i,
    input  logic [SAT_W-1:0] sat_limit_i,
    output logic [W-1:0]     sample_o,
    output logic             sat_o
);
    typedef struct packed {
        logic [ORDER_MAX-1:0][W-1:0] integ;
        logic [ORDER_MAX-1:0][W-1:0] dly;
        logic [W-1:0]                smp;
        logic [SAT_W-1:0]            run;
        logic                        prev;
        logic                        sticky;
        logic                        sat;
    } chan_t;

    chan_t s_d, s_q;
    logic [ORDER_MAX-1:0][W-1:0] acc;
    logic [ORDER_MAX-1:0][W-1:0] dly_n;
    logic [W-1:0]                xin, cval, yv;
    logic [SAT_W-1:0]            run_n;
    logic                        hit;
    logic signed [W:0]           lim;

    always_comb begin
        xin    = bit_i ? W'(1) : '1;
        acc[0] = s_q.integ[0] + xin;
        for (int s = 1; s < ORDER_MAX; s++) begin
            acc[s] = s_q.integ[s] + acc[s-1];
        end
        cval = acc[0];
        for (int s = 1; s < ORDER_MAX; s++) begin
            if (s == int'(order_i) - 1) cval = acc[s];
        end
        dly_n = s_q.dly;
        for (int s = 0; s < ORDER_MAX; s++) begin
            if (s < int'(order_i)) begin
                dly_n[s] = cval;
                cval     = cval - s_q.dly[s];
            end
        end
        yv  = cval;
        lim = $signed((W+1)'(1) << (int'(order_i) * int'(log2r_i)));

        if (s_q.run != '0 && bit_i == s_q.prev) begin
            run_n = (s_q.run == '1) ? s_q.run : s_q.run + 1'b1;
        end else begin
            run_n = SAT_W'(1);
        end
        hit = (sat_limit_i != '0) && (run_n >= sat_limit_i);

        s_d = s_q;
        if (clr_i) begin
            s_d.integ  = '0;
            s_d.dly    = '0;
            s_d.run    = '0;
            s_d.prev   = 1'b0;
            s_d.sticky = 1'b0;
        end else if (tick_i) begin
            s_d.integ  = acc;
            s_d.run    = run_n;
            s_d.prev   = bit_i;
            s_d.sticky = s_q.sticky | hit;
            if (win_end_i) s_d.dly = dly_n;
            if (emit_i) begin
                s_d.smp    = yv;
                s_d.sat    = s_q.sticky | hit;
                s_d.sticky = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign sample_o = s_q.smp;
    assign sat_o    = s_q.sat;

    // R4
    full_scale_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        emit_i |-> ($signed({yv[W-1], yv}) <= lim && $signed({yv[W-1], yv}) >= -lim));

endmodule

// File: rtl/sdm_decim.sv
module sdm_decim
    import sdm_pkg::*;
#(
    parameter int NCH          = 3,
    parameter int LOG2_OSR_MIN = 4,
    parameter int LOG2_OSR_MAX = 8,
    parameter int SAT_W        = 12,
    parameter int STALL_CYCLES = 64,
    parameter int OSR_SEL_W    = $clog2(LOG2_OSR_MAX - LOG2_OSR_MIN + 1),
    parameter int W            = 2 + sdm_pkg::ORDER_MAX * LOG2_OSR_MAX
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 mclk_i,
    input  logic [NCH-1:0]       mdat_i,
    input  logic [OSR_SEL_W-1:0] osr_sel_i,
    input  logic [1:0]           order_i,
    input  logic [SAT_W-1:0]     sat_limit_i,
    output logic [NCH*W-1:0]     sample_o,
    output logic                 valid_o,
    output logic [NCH-1:0]       sat_o,
    output logic                 stall_o
);
    localparam int LR_W = $clog2(LOG2_OSR_MAX + 1);

    logic                      tick, clr, win_end, emit;
    logic [NCH-1:0]            bits;
    logic [1:0]                ord;
    logic [LR_W-1:0]           lr;
    logic [NCH-1:0][W-1:0]     smp_w;

    sdm_front #(.NCH(NCH), .STALL_CYCLES(STALL_CYCLES)) front_i (
        .clk(clk), .rst_n(rst_n), .mclk_i(mclk_i), .mdat_i(mdat_i),
        .emit_i(emit), .tick_o(tick), .bit_o(bits), .stall_o(stall_o)
    );

    sdm_frame #(
        .LOG2_OSR_MIN(LOG2_OSR_MIN), .LOG2_OSR_MAX(LOG2_OSR_MAX),
        .OSR_SEL_W(OSR_SEL_W), .LR_W(LR_W)
    ) frame_i (
        .clk(clk), .rst_n(rst_n), .tick_i(tick), .osr_sel_i(osr_sel_i),
        .order_i(order_i), .clr_o(clr), .win_end_o(win_end), .emit_o(emit),
        .valid_o(valid_o), .order_o(ord), .log2r_o(lr)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_chan
        sdm_chan #(.W(W), .SAT_W(SAT_W), .LR_W(LR_W)) chan_i (
            .clk(clk), .rst_n(rst_n), .clr_i(clr), .tick_i(tick),
            .bit_i(bits[c]), .win_end_i(win_end), .emit_i(emit),
            .order_i(ord), .log2r_i(lr), .sat_limit_i(sat_limit_i),
            .sample_o(smp_w[c]), .sat_o(sat_o[c])
        );
    end

    assign sample_o = smp_w;

    // R7
    hold_between_strobes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_o |-> ($stable(sample_o) && $stable(sat_o)));

endmodule

// File: tb/sdm_decim_tb.sv
module sdm_decim_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NCH   = 3;
    localparam int W     = 26;
    localparam int SAT_W = 12;
    localparam int HMAX  = 4096;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             mclk = 1'b0;
    logic [NCH-1:0]   mdat = '0;
    logic [2:0]       osr_sel = 3'd0;
    logic [1:0]       order_c = 2'd1;
    logic [SAT_W-1:0] sat_lim = '0;
    logic [NCH*W-1:0] sample;
    logic             valid;
    logic [NCH-1:0]   sat;
    logic             stall;

    always #(CLK_PERIOD/2) clk = ~clk;

    sdm_decim dut_i (
        .clk(clk), .rst_n(rst_n), .mclk_i(mclk), .mdat_i(mdat),
        .osr_sel_i(osr_sel), .order_i(order_c), .sat_limit_i(sat_lim),
        .sample_o(sample), .valid_o(valid), .sat_o(sat), .stall_o(stall)
    );

    int     checks = 0;
    int     fails  = 0;
    bit     hist [NCH][HMAX];
    int     runh [NCH][HMAX];
    int     cnt = 0;
    int     mode [NCH];
    bit     run_en = 1'b0;
    bit     mon_en = 1'b0;
    int     ord_e = 1;
    int     osr = 16;
    int     lim = 0;
    int     emitted = 0;
    int     prev_end = -1;
    longint h [HMAX];
    int     hlen = 1;

    task automatic check(input string req, input longint act, input longint exp_v);
        checks++;
        if (act != exp_v) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp_v);
        end
    endtask

    // N-fold convolution of a length-osr run of ones
    task automatic build_h();
        longint t [HMAX];
        for (int j = 0; j < HMAX; j++) h[j] = (j < osr) ? 64'd1 : 64'd0;
        hlen = osr;
        for (int n = 1; n < ord_e; n++) begin
            for (int j = 0; j < hlen + osr - 1; j++) begin
                t[j] = 0;
                for (int i = 0; i < osr; i++) begin
                    if (j - i >= 0 && j - i < hlen) t[j] += h[j-i];
                end
            end
            hlen = hlen + osr - 1;
            for (int j = 0; j < hlen; j++) h[j] = t[j];
        end
    endtask

    function automatic longint model_y(input int ch, input int ie);
        longint a = 0;
        for (int j = 0; j < hlen; j++) begin
            if (ie - j >= 0) a += hist[ch][ie-j] ? h[j] : -h[j];
        end
        return a;
    endfunction

    function automatic longint model_sat(input int ch, input int lo, input int hi);
        if (lim == 0) return 0;
        for (int i = lo; i <= hi; i++) if (runh[ch][i] >= lim) return 1;
        return 0;
    endfunction

    function automatic bit gen_bit(input int m, input int idx);
        case (m)
            1:       return 1'b1;
            2:       return 1'b0;
            3:       return idx[0];
            4:       return ($urandom % 4) != 0;
            default: return $urandom % 2;
        endcase
    endfunction

    function automatic longint chan_val(input int ch);
        return longint'($signed(sample[ch*W +: W]));
    endfunction

    // modulator model: data set after the falling edge, sampled on the next rise
    initial begin
        forever begin
            @(negedge clk);
            if (run_en && cnt < HMAX) begin
                for (int ch = 0; ch < NCH; ch++) begin
                    bit b;
                    b = gen_bit(mode[ch], cnt);
                    mdat[ch] = b;
                    hist[ch][cnt] = b;
                    runh[ch][cnt] = (cnt > 0 && hist[ch][cnt-1] == b) ? runh[ch][cnt-1] + 1 : 1;
                end
                cnt++;
                repeat (3) @(negedge clk);
                mclk = 1'b1;
                repeat (3) @(negedge clk);
                mclk = 1'b0;
            end
        end
    end

    // strobe monitor
    initial begin
        forever begin
            @(negedge clk);
            if (valid && mon_en) begin
                int k;
                int ie;
                logic [NCH*W-1:0] held;
                logic [NCH-1:0]   held_sat;
                k  = ord_e + 1 + emitted;
                ie = k * osr - 1;
                if (emitted == 0) begin
                    checks++;
                    if (cnt < k * osr || cnt > k * osr + 1) begin
                        fails++;
                        $display("FAIL R5: first strobe after %0d samples, expected %0d", cnt, k * osr);
                    end
                end
                for (int ch = 0; ch < NCH; ch++) begin
                    check("R1 sample", chan_val(ch), model_y(ch, ie));
                    check("R8 saturation", longint'(sat[ch]), model_sat(ch, prev_end + 1, ie));
                end
                prev_end = ie;
                emitted++;
                held = sample;
                held_sat = sat;
                @(negedge clk);
                check("R6 strobe width", longint'(valid), 0);
                check("R7 hold", longint'(held == sample && held_sat == sat), 1);
            end
        end
    end

    task automatic set_cfg(input int sel, input int oc, input int sl,
                           input int m0, input int m1, input int m2,
                           input int eff_ord, input int eff_osr);
        run_en = 1'b0;
        repeat (12) @(negedge clk);
        mon_en   = 1'b0;
        osr_sel  = 3'(sel);
        order_c  = 2'(oc);
        sat_lim  = SAT_W'(sl);
        lim      = sl;
        mode[0]  = m0;
        mode[1]  = m1;
        mode[2]  = m2;
        ord_e    = eff_ord;
        osr      = eff_osr;
        build_h();
        cnt      = 0;
        emitted  = 0;
        prev_end = -1;
        repeat (3) @(negedge clk);
        mon_en = 1'b1;
        run_en = 1'b1;
    endtask

    initial begin
        void'($urandom(32'd20240));
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        // R11 reset state
        check("R11 sample", longint'(sample == '0), 1);
        check("R11 valid", longint'(valid), 0);
        check("R11 sat", longint'(sat), 0);
        check("R11 stall", longint'(stall), 0);

        // sinc1, R=16: random, alternating, all ones with limit 8
        set_cfg(0, 1, 8, 0, 3, 1, 1, 16);
        wait (emitted == 6);
        check("R4 alternating sinc1", chan_val(1), 0);
        check("R4 ones sinc1", chan_val(2), 16);
        check("R8 ones flagged", longint'(sat[2]), 1);

        // sinc2, R=32 with a clock pause
        set_cfg(1, 2, 200, 4, 0, 2, 2, 32);
        wait (emitted == 3);
        run_en = 1'b0;
        repeat (40) @(negedge clk);
        check("R10 no stall before limit", longint'(stall), 0);
        repeat (100) @(negedge clk);
        check("R10 stall raised", longint'(stall), 1);
        run_en = 1'b1;
        wait (emitted == 4);
        check("R10 stall cleared on strobe", longint'(stall), 0);
        wait (emitted == 8);
        check("R4 zeros sinc2", chan_val(2), -1024);
        check("R2 ratio 32", chan_val(2), -(32 * 32));

        // sinc3, R=16, detection off
        set_cfg(0, 3, 0, 1, 2, 3, 3, 16);
        wait (emitted == 4);
        check("R4 ones sinc3", chan_val(0), 4096);
        check("R4 zeros sinc3", chan_val(1), -4096);
        check("R9 limit zero ignores ones", longint'(sat[0]), 0);
        check("R9 limit zero ignores zeros", longint'(sat[1]), 0);

        // sinc3, R=256: widest result
        set_cfg(4, 3, 20, 0, 1, 3, 3, 256);
        wait (emitted == 2);
        check("R4 ones full scale", chan_val(1), 64'd16777216);
        check("R8 long run flagged", longint'(sat[1]), 1);

        // order code 0 and ratio code beyond range
        set_cfg(6, 0, 4095, 2, 0, 4, 1, 256);
        wait (emitted == 3);
        check("R3 code zero is sinc1", chan_val(0), -256);
        check("R2 clamped ratio", longint'(sat[0]), 0);

        // sinc2, R=64, limit 1 flags every window
        set_cfg(2, 2, 1, 3, 0, 1, 2, 64);
        wait (emitted == 3);
        check("R3 sinc2 ones", chan_val(2), 4096);
        check("R8 limit one", longint'(sat), 7);

        run_en = 1'b0;
        repeat (20) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule